// File: doc/BRIEF.md
# Timer Event Capture Unit

This block stamps external events with the value of a free-running 16-bit timer count. An event is a rising or a falling transition, chosen by a control input, on either a dedicated event pin or an alternate comparator signal. The chosen signal is first brought into the clock domain by a two-stage synchronizer. It then passes through an optional glitch filter. When an event qualifies, the block copies the count into a 16-bit capture register and sets a capture flag. While the interrupt enable is high, that flag drives an interrupt request.

A host reaches the block over an 8-bit bus. The capture register is read as two bytes. Reading the low byte also parks the high byte in a temporary latch. A later high-byte read returns that latch, so the two bytes always belong to the same capture. The flag clears when the interrupt is acknowledged, or when the host writes a one to bit 0 of the flag location.

Top module: `icu_capture_unit`

## Requirements
- R1: During and after synchronous reset, and before any event, the flag, the interrupt request and both capture bytes read as zero.
- R2: With `src_sel`=0 only `evt_pin` can trigger a capture, and with `src_sel`=1 only `cmp_in` can. Activity on the other input leaves the flag clear.
- R3: With `edge_rise`=1 only a 0-to-1 transition of the selected input triggers a capture, and with `edge_rise`=0 only a 1-to-0 transition does. The opposite transition leaves the flag clear.
- R4: With the filter off, a transition that is presented to the input just before clock edge k is captured at edge k+2. The capture register then holds the `cnt_val` that was present at edge k+2.
- R5: With `filt_en`=1, the filtered level changes only after 4 consecutive equal synchronized samples. A pulse lasting 1 to 3 cycles causes no capture. An accepted transition is captured 4 edges later than in R4, at edge k+6.
- R6: The flag rises at the same clock edge at which the capture register takes the new count. It does not rise before that edge.
- R7: `irq` is high exactly when the flag is set and `cap_ie` is 1.
- R8: A one-cycle `int_ack` pulse clears the flag.
- R9: A bus write to address 2'b10 with data bit 0 equal to 1 clears the flag. With bit 0 equal to 0 the flag is unchanged. A read at address 2'b10 returns the flag in bit 0, with the other bits zero.
- R10: A read at address 2'b00 returns capture bits 7:0 in the same cycle and latches capture bits 15:8 into the temporary register. A read at 2'b01 returns the temporary register, even if a new capture has happened since the low read.
- R11: If a capture and a clear (acknowledge or write of one) fall on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pin | input | 1 | External event pin (asynchronous) |
| cmp_in | input | 1 | Alternate comparator event signal (asynchronous) |
| src_sel | input | 1 | 0 selects evt_pin, 1 selects cmp_in |
| edge_rise | input | 1 | 1 captures on rising transitions, 0 on falling |
| filt_en | input | 1 | Enables the 4-sample glitch filter |
| cap_ie | input | 1 | Capture interrupt enable |
| cnt_val | input | 16 | Free-running timer count |
| int_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| bus_addr | input | 2 | 00 low byte, 01 high byte (temporary), 10 flag |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd, zero otherwise |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench uses a timer count that steps by one each cycle, so a captured value shows the exact edge at which capture happened. That value separates the unfiltered latency from the filtered latency, which is 4 cycles longer. Random episodes vary the source, the edge polarity, the filter setting and the enable, and drive noise on the unselected input. These episodes show whether the source mux and the edge polarity are honoured. Short pulses of 1 to 3 cycles with the filter on and off separate real filtering from pass-through. A low-byte read followed by a new capture and then a high-byte read shows whether the temporary latch is used rather than the live register. Clears timed onto the capture edge show which of set and clear has priority.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;

    localparam int ICU_BUS_W = 8;
    localparam int ICU_CNT_W = 2 * ICU_BUS_W;

    typedef enum logic [1:0] {
        REG_CAP_LO = 2'b00,
        REG_CAP_HI = 2'b01,
        REG_FLAG   = 2'b10,
        REG_NONE   = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic src_alt;
        logic rise;
        logic filt_on;
    } trig_cfg_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
        return rise ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/icu_sync.sv
`timescale 1ns/1ps
module icu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
`timescale 1ns/1ps
module icu_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic en,
    output logic dout
);
    localparam int HW = LEN - 1;

    logic [HW-1:0] hist;
    logic          lvl_q;
    logic          all_same;

    always_comb all_same = (hist == {HW{din}});

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            lvl_q <= 1'b0;
        end else begin
            hist[0] <= din;
            for (int i = 1; i < HW; i++) begin
                hist[i] <= hist[i-1];
            end
            if (all_same) begin
                lvl_q <= din;
            end
        end
    end

    assign dout = en ? lvl_q : din;

    // R5: the filtered level only moves to a value the history already agreed on
    a_r5_filter_settles: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> ($past(hist) == {HW{lvl_q}}));
endmodule

// File: rtl/icu_edge.sv
`timescale 1ns/1ps
module icu_edge
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign hit = edge_hit(lvl, prev_q, rise);
endmodule

// File: rtl/icu_capture_unit.sv
`timescale 1ns/1ps
module icu_capture_unit
    import icu_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_pin,
    input  logic                 cmp_in,
    input  logic                 src_sel,
    input  logic                 edge_rise,
    input  logic                 filt_en,
    input  logic                 cap_ie,
    input  logic [ICU_CNT_W-1:0] cnt_val,
    input  logic                 int_ack,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ICU_BUS_W-1:0] bus_wdata,
    output logic [ICU_BUS_W-1:0] bus_rdata,
    output logic                 cap_flag,
    output logic                 irq
);
    trig_cfg_t              cfg;
    reg_sel_e               sel;
    logic                   raw_src;
    logic                   sync_lvl;
    logic                   filt_lvl;
    logic                   cap_event;
    logic                   sw_clear;
    logic                   lo_read;
    logic [ICU_CNT_W-1:0]   cap_reg;
    logic [ICU_BUS_W-1:0]   temp_hi;
    logic                   flag_q;

    always_comb begin
        cfg.src_alt = src_sel;
        cfg.rise    = edge_rise;
        cfg.filt_on = filt_en;
        sel         = reg_sel_e'(bus_addr);
        raw_src     = cfg.src_alt ? cmp_in : evt_pin;
        sw_clear    = bus_wr && (sel == REG_FLAG) && bus_wdata[0];
        lo_read     = bus_rd && (sel == REG_CAP_LO);
    end

    icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_src),
        .q   (sync_lvl)
    );

    icu_filter #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_lvl),
        .en   (cfg.filt_on),
        .dout (filt_lvl)
    );

    icu_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (filt_lvl),
        .rise (cfg.rise),
        .hit  (cap_event)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_reg <= '0;
            flag_q  <= 1'b0;
            temp_hi <= '0;
        end else begin
            if (cap_event) begin
                cap_reg <= cnt_val;
            end
            if (cap_event) begin
                flag_q <= 1'b1;
            end else if (int_ack || sw_clear) begin
                flag_q <= 1'b0;
            end
            if (lo_read) begin
                temp_hi <= cap_reg[ICU_CNT_W-1:ICU_BUS_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                REG_CAP_LO: bus_rdata = cap_reg[ICU_BUS_W-1:0];
                REG_CAP_HI: bus_rdata = temp_hi;
                REG_FLAG:   bus_rdata = {{(ICU_BUS_W-1){1'b0}}, flag_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign cap_flag = flag_q;
    assign irq      = flag_q & cap_ie;

    // R4: a capture stores the count present at the capturing edge
    a_r4_value: assert property (@(posedge clk) disable iff (rst)
        cap_event |=> (cap_reg == $past(cnt_val)));

    // R6 and R11: the flag is set after every capture edge, even with a clear pending
    a_r6_flag_on_capture: assert property (@(posedge clk) disable iff (rst)
        cap_event |=> cap_flag);

    // R7: no request while the enable is low
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !cap_ie |-> !irq);

    // R8: an acknowledge without a coincident capture clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !cap_event) |=> !cap_flag);

    // R9: writing zero to the flag location keeps a set flag
    a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && bus_wr && (bus_addr == 2'b10) && !bus_wdata[0] && !int_ack) |=> cap_flag);

    // R10: a low-byte read parks the high byte of the same capture
    a_r10_temp_latch: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == 2'b00)) |=> (temp_hi == $past(cap_reg[ICU_CNT_W-1:ICU_BUS_W])));
endmodule

// File: tb/sim_icu_capture_unit.sv
`timescale 1ns/1ps
module sim_icu_capture_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        evt_pin, cmp_in, src_sel, edge_rise, filt_en, cap_ie, int_ack;
    logic [15:0] tcnt;
    logic [1:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        cap_flag, irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    icu_capture_unit u0 (
        .clk(clk), .rst(rst), .evt_pin(evt_pin), .cmp_in(cmp_in),
        .src_sel(src_sel), .edge_rise(edge_rise), .filt_en(filt_en),
        .cap_ie(cap_ie), .cnt_val(tcnt), .int_ack(int_ack),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_flag(cap_flag), .irq(irq)
    );

    task automatic tick();
        @(negedge clk);
        tcnt = tcnt + 16'd1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_capture(input logic [15:0] start, input bit filt);
        return start + (filt ? 16'd6 : 16'd2);
    endfunction

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic drive_sel(input bit v);
        if (src_sel) cmp_in = v;
        else         evt_pin = v;
    endtask

    task automatic drive_other(input bit v);
        if (src_sel) evt_pin = v;
        else         cmp_in = v;
    endtask

    task automatic arm(input bit src, input bit rise, input bit filt);
        src_sel   = src;
        edge_rise = rise;
        filt_en   = filt;
        evt_pin   = ~rise;
        cmp_in    = ~rise;
        repeat (10) tick();
        bus_write(2'b10, 8'h01);
        #1 check("R9 write one clears", {15'd0, cap_flag}, 16'd0);
    endtask

    task automatic episode(input bit src, input bit rise, input bit filt, input bit ie,
                           input logic [15:0] start);
        logic [7:0] lo, hi;
        int lat;
        lat = filt ? 6 : 2;
        cap_ie = ie;
        arm(src, rise, filt);
        // R2: toggling the unselected input must not capture
        repeat (10) begin
            drive_other($urandom_range(0, 1) == 1);
            tick();
        end
        #1 check("R2 unselected input ignored", {15'd0, cap_flag}, 16'd0);
        tcnt = start;
        drive_sel(rise);
        repeat (lat) begin
            tick();
            drive_other($urandom_range(0, 1) == 1);
        end
        #1 check("R6 flag not before capture edge", {15'd0, cap_flag}, 16'd0);
        tick();
        #1 check("R6 flag at capture edge", {15'd0, cap_flag}, 16'd1);
        check("R7 irq follows enable", {15'd0, irq}, {15'd0, ie});
        bus_read(2'b00, lo);
        bus_read(2'b01, hi);
        check(filt ? "R5 filtered capture value" : "R4 capture value",
              {hi, lo}, exp_capture(start, filt));
        bus_read(2'b10, lo);
        check("R9 flag readback", {8'd0, lo}, 16'd1);
        bus_write(2'b10, 8'hFE);
        #1 check("R9 write zero keeps flag", {15'd0, cap_flag}, 16'd1);
        if ($urandom_range(0, 1) == 1) begin
            int_ack = 1'b1;
            tick();
            int_ack = 1'b0;
            #1 check("R8 ack clears flag", {15'd0, cap_flag}, 16'd0);
        end else begin
            bus_write(2'b10, 8'h01);
            #1 check("R9 write one clears flag", {15'd0, cap_flag}, 16'd0);
        end
        // R3: opposite transition must not capture
        drive_sel(~rise);
        repeat (12) tick();
        #1 check("R3 opposite edge ignored", {15'd0, cap_flag}, 16'd0);
    endtask

    task automatic glitch(input bit filt, input int w);
        cap_ie = 1'b1;
        arm(1'b0, 1'b1, filt);
        drive_sel(1'b1);
        repeat (w) tick();
        drive_sel(1'b0);
        repeat (12) tick();
        #1 check(filt ? "R5 short pulse filtered" : "R5 pulse passes unfiltered",
                 {15'd0, cap_flag}, filt ? 16'd0 : 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, lo, hi;
        void'($urandom(32'd11));
        rst = 1'b1; tcnt = 16'd0; evt_pin = 1'b0; cmp_in = 1'b0;
        src_sel = 1'b0; edge_rise = 1'b1; filt_en = 1'b0; cap_ie = 1'b1;
        int_ack = 1'b0; bus_addr = 2'b00; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        repeat (3) tick();
        #1 check("R1 flag in reset", {15'd0, cap_flag}, 16'd0);
        rst = 1'b0;
        tick();
        #1 check("R1 flag after reset", {15'd0, cap_flag}, 16'd0);
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        bus_read(2'b00, d);
        check("R1 low byte after reset", {8'd0, d}, 16'd0);
        bus_read(2'b01, d);
        check("R1 high byte after reset", {8'd0, d}, 16'd0);

        // directed episodes covering every source, polarity and filter setting
        episode(1'b0, 1'b1, 1'b0, 1'b1, 16'h1000);
        episode(1'b1, 1'b0, 1'b0, 1'b0, 16'h20F0);
        episode(1'b0, 1'b0, 1'b1, 1'b1, 16'h3FFB);
        episode(1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFC);

        // R10: atomic read through the temporary register
        arm(1'b0, 1'b1, 1'b0);
        tcnt = 16'h122E; drive_sel(1'b1);
        repeat (4) tick();
        bus_read(2'b00, lo);
        check("R10 low byte of first capture", {8'd0, lo}, 16'h0030);
        drive_sel(1'b0); repeat (6) tick();
        tcnt = 16'hAB00; drive_sel(1'b1);
        repeat (4) tick();
        bus_read(2'b01, hi);
        check("R10 high byte from temporary", {8'd0, hi}, 16'h0012);
        bus_read(2'b00, lo);
        bus_read(2'b01, hi);
        check("R10 new pair consistent", {hi, lo}, 16'hAB02);

        // R11: capture and acknowledge on the same edge
        arm(1'b0, 1'b1, 1'b0);
        drive_sel(1'b1);
        repeat (2) tick();
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
        #1 check("R11 capture beats acknowledge", {15'd0, cap_flag}, 16'd1);
        // R11: capture and write-one clear on the same edge
        arm(1'b0, 1'b1, 1'b0);
        drive_sel(1'b1);
        repeat (2) tick();
        bus_write(2'b10, 8'h01);
        #1 check("R11 capture beats write clear", {15'd0, cap_flag}, 16'd1);

        // short pulses, filter on and off
        for (int w = 1; w <= 3; w++) begin
            glitch(1'b1, w);
            glitch(1'b0, w);
        end

        // random episodes
        for (int n = 0; n < 40; n++) begin
            episode($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    16'($urandom));
        end
        for (int n = 0; n < 10; n++) begin
            glitch(1'b1, $urandom_range(1, 3));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule